// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns a fetch virtual address into a physical address for the instruction side of a core. Each request carries the virtual address, the least significant bit of the fetch PC, a physical-mode flag, the current privilege mode and the current address-space number. The block picks one of four routes. A privileged-code marker (PC bit 0 set) bypasses translation. The physical flag passes the address straight through. A kernel-only direct-map window, selected by a fixed tag in the upper virtual bits, maps to a physical address with its top nibble sign-extended. Every other address is resolved through an external, combinational page-lookup port and then checked for execute permission.

The result is a physical address, an uncacheable flag and a two-bit fault code. The codes are 0 none, 1 access violation, 2 page miss and 3 machine check.

Requests enter on a valid/ready stream and results leave on a second one, through a single output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` one cycle later and holds there until `out_ready` is high. `in_ready` is high when the output register is empty or being drained in the same cycle. The lookup port is sampled in the cycle in which the request is presented.

Top module: `ift_translator`

## Requirements
- R1: With `in_pc_lsb` = 1, `out_pa` is `in_va` with bits 1:0 cleared and truncated to 44 bits. The fault is 0 and `out_uncached` is 0, even when bit 43 is set.
- R2: With `in_pc_lsb` = 0 and `in_phys` = 1, the candidate physical address is `in_va` unchanged, and R9/R10 then apply.
- R3: On the translated paths (neither R1 nor R2), a virtual address whose bits 63:47 are not all equal gives fault 1.
- R4: A canonical address with bits 47:41 = 7'h7e, fetched in a mode other than 0 (kernel), gives fault 1.
- R5: The same window in mode 0 maps to `in_va` masked to 44 bits. Bits 43:40 are then forced to ones if bit 40 is 1; otherwise everything above bit 39 is cleared.
- R6: Any other canonical address is looked up with page number `in_va[47:13]` and `in_asn`. When `lk_hit` = 0 the fault is 2.
- R7: On a hit, the physical address is `lk_ppn` shifted left by 13, plus `in_va[12:0]` with bits 1:0 cleared.
- R8: On a hit where bit `in_mode` of `lk_xre` is 0, the fault is 1.
- R9: On paths R2, R5 and R7, a candidate address with any bit at or above bit 44 set gives fault 3.
- R10: On the same paths, a candidate with bit 43 set sets `out_uncached` and clears bits 42:35 of `out_pa`.
- R11: A request is taken when `in_valid` and `in_ready` are both high, and its result is valid the next cycle. While `out_valid` is high and `out_ready` is low, `in_ready` is low and all outputs hold.
- R12: Reset empties the output stage (`out_valid` = 0).
- R13: `lk_req` is high only for a valid request on the lookup path (R6), never for R1, R2, R3 or R4.
- R14: Whenever the fault is nonzero, `out_pa` is 0 and `out_uncached` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_va | input | 64 | Fetch virtual address |
| in_pc_lsb | input | 1 | Bit 0 of the fetch PC (privileged-code marker) |
| in_phys | input | 1 | Physical-mode request |
| in_mode | input | 2 | Current mode, 0 = kernel |
| in_asn | input | 8 | Current address-space number |
| lk_req | output | 1 | Lookup port request |
| lk_vpn | output | 35 | Virtual page number to look up |
| lk_asn | output | 8 | Address-space number to look up |
| lk_hit | input | 1 | Lookup hit, same cycle |
| lk_ppn | input | 32 | Physical page number on hit |
| lk_xre | input | 4 | Execute-enable mask, one bit per mode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready |
| out_pa | output | 44 | Physical address |
| out_uncached | output | 1 | Access is uncacheable |
| out_fault | output | 2 | 0 none, 1 access violation, 2 page miss, 3 machine check |

## Verification
The properties assume two things about the environment. The consumer may stall at any time. The lookup responder answers combinationally from `lk_vpn`/`lk_asn` in the same cycle, with no dependence on earlier cycles. The bench keeps to this: its responder is a small combinational table. Random traffic runs with `out_ready` held high, and a directed sequence stalls the consumer while a second request waits at the input. Random addresses are drawn per route, so the direct-map window, non-canonical tops, table hits with random page numbers (some high enough to reach bit 43 or 44) and misses all occur.

// File: rtl/ift_pkg.sv
package ift_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_ACV  = 2'd1,
    FLT_MISS = 2'd2,
    FLT_MCHK = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    RT_PRIV  = 3'd0,
    RT_PHYS  = 3'd1,
    RT_BADVA = 3'd2,
    RT_SUPER = 3'd3,
    RT_TLB   = 3'd4
  } route_e;
endpackage

// File: rtl/ift_route.sv
module ift_route import ift_pkg::*; #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 126
) (
  input  logic [VA_W-1:0] va,
  input  logic            pc_lsb,
  input  logic            phys,
  output route_e          route
);
  localparam int SP_W = VA_IMPL - SP_LO;

  logic [VA_W-VA_IMPL:0] top_bits;
  logic canon, window;

  assign top_bits = va[VA_W-1:VA_IMPL-1];
  assign canon    = (&top_bits) | ~(|top_bits);
  assign window   = (va[VA_IMPL-1:SP_LO] == SP_W'(SP_TAG));

  always_comb begin
    if (pc_lsb)      route = RT_PRIV;
    else if (phys)   route = RT_PHYS;
    else if (!canon) route = RT_BADVA;
    else if (window) route = RT_SUPER;
    else             route = RT_TLB;
  end
endmodule

// File: rtl/ift_compose.sv
module ift_compose import ift_pkg::*; #(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int MODE_W     = 2,
  parameter int EXT_BIT    = 40,
  parameter int KERNEL     = 0,
  localparam int NMODE     = 1 << MODE_W
) (
  input  route_e            route,
  input  logic [VA_W-1:0]   va,
  input  logic [MODE_W-1:0] mode,
  input  logic              hit,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [NMODE-1:0]  xre,
  output logic [VA_W-1:0]   raw,
  output flt_e              flt,
  output logic              chk
);
  localparam logic [VA_W-1:0] IMPL_MASK = {{(VA_W-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic [VA_W-1:0] page_base, page_off;

  assign page_base = VA_W'(ppn) << PAGE_SHIFT;
  assign page_off  = VA_W'({va[PAGE_SHIFT-1:2], 2'b00});

  always_comb begin
    raw = '0;
    flt = FLT_NONE;
    chk = 1'b1;
    unique case (route)
      RT_PRIV: begin
        raw = {va[VA_W-1:2], 2'b00} & IMPL_MASK;
        chk = 1'b0;
      end
      RT_PHYS:  raw = va;
      RT_BADVA: flt = FLT_ACV;
      RT_SUPER: begin
        if (mode != MODE_W'(KERNEL)) begin
          flt = FLT_ACV;
        end else begin
          raw = va & IMPL_MASK;
          if (raw[EXT_BIT]) raw[PA_W-1:EXT_BIT] = '1;
          else              raw[VA_W-1:EXT_BIT] = '0;
        end
      end
      default: begin
        if (!hit) begin
          flt = FLT_MISS;
        end else begin
          raw = page_base | page_off;
          if (!xre[mode]) flt = FLT_ACV;
        end
      end
    endcase
  end
endmodule

// File: rtl/ift_finish.sv
module ift_finish import ift_pkg::*; #(
  parameter int VA_W   = 64,
  parameter int PA_W   = 44,
  parameter int CLR_LO = 35,
  localparam int CLR_HI = PA_W - 2
) (
  input  logic [VA_W-1:0] raw,
  input  flt_e            flt_in,
  input  logic            chk,
  output logic [PA_W-1:0] pa,
  output logic            uc,
  output flt_e            flt
);
  always_comb begin
    pa  = '0;
    uc  = 1'b0;
    flt = flt_in;
    if (flt_in == FLT_NONE) begin
      if (chk && (|raw[VA_W-1:PA_W])) begin
        flt = FLT_MCHK;
      end else begin
        pa = raw[PA_W-1:0];
        if (chk && pa[PA_W-1]) begin
          uc = 1'b1;
          pa[CLR_HI:CLR_LO] = '0;
        end
      end
    end
  end
endmodule

// File: rtl/ift_translator.sv
module ift_translator import ift_pkg::*; #(
  parameter int VA_W       = 64,
  parameter int VA_IMPL    = 48,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int ASN_W      = 8,
  parameter int MODE_W     = 2,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 126,
  parameter int EXT_BIT    = 40,
  parameter int CLR_LO     = 35,
  parameter int KERNEL     = 0,
  localparam int VPN_W     = VA_IMPL - PAGE_SHIFT,
  localparam int NMODE     = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VA_W-1:0]   in_va,
  input  logic              in_pc_lsb,
  input  logic              in_phys,
  input  logic [MODE_W-1:0] in_mode,
  input  logic [ASN_W-1:0]  in_asn,
  output logic              lk_req,
  output logic [VPN_W-1:0]  lk_vpn,
  output logic [ASN_W-1:0]  lk_asn,
  input  logic              lk_hit,
  input  logic [PPN_W-1:0]  lk_ppn,
  input  logic [NMODE-1:0]  lk_xre,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_pa,
  output logic              out_uncached,
  output logic [1:0]        out_fault
);
  route_e          route;
  logic [VA_W-1:0] raw;
  flt_e            pre_flt, fin_flt;
  logic            chk;
  logic [PA_W-1:0] fin_pa;
  logic            fin_uc;

  ift_route #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
  ) u_route (
    .va(in_va), .pc_lsb(in_pc_lsb), .phys(in_phys), .route(route)
  );

  assign lk_req = in_valid && (route == RT_TLB);
  assign lk_vpn = in_va[VA_IMPL-1:PAGE_SHIFT];
  assign lk_asn = in_asn;

  ift_compose #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W),
    .MODE_W(MODE_W), .EXT_BIT(EXT_BIT), .KERNEL(KERNEL)
  ) u_compose (
    .route(route), .va(in_va), .mode(in_mode), .hit(lk_hit),
    .ppn(lk_ppn), .xre(lk_xre), .raw(raw), .flt(pre_flt), .chk(chk)
  );

  ift_finish #(
    .VA_W(VA_W), .PA_W(PA_W), .CLR_LO(CLR_LO)
  ) u_finish (
    .raw(raw), .flt_in(pre_flt), .chk(chk),
    .pa(fin_pa), .uc(fin_uc), .flt(fin_flt)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_pa       <= '0;
      out_uncached <= 1'b0;
      out_fault    <= FLT_NONE;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pa       <= fin_pa;
        out_uncached <= fin_uc;
        out_fault    <= fin_flt;
      end
    end
  end
endmodule

// File: rtl/ift_checker.sv
module ift_checker #(
  parameter int PA_W   = 44,
  parameter int CLR_LO = 35,
  localparam int CLR_HI = PA_W - 2
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_pc_lsb,
  input logic            in_phys,
  input logic            lk_req,
  input logic            out_valid,
  input logic            out_ready,
  input logic [PA_W-1:0] out_pa,
  input logic            out_uncached,
  input logic [1:0]      out_fault
);
  p_reset_r12: assert property (@(posedge clk) rst |=> !out_valid);

  p_take_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pa)
      && $stable(out_fault) && $stable(out_uncached));

  p_stall_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_lookup_r13: assert property (@(posedge clk) disable iff (rst)
    lk_req |-> in_valid && !in_pc_lsb && !in_phys);

  p_uncached_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_uncached |-> out_pa[PA_W-1] && (out_pa[CLR_HI:CLR_LO] == '0));

  p_fault_zero_r14: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_fault != 2'd0) |-> (out_pa == '0) && !out_uncached);
endmodule

bind ift_translator ift_checker #(.PA_W(PA_W), .CLR_LO(CLR_LO)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_pc_lsb(in_pc_lsb), .in_phys(in_phys), .lk_req(lk_req),
  .out_valid(out_valid), .out_ready(out_ready), .out_pa(out_pa),
  .out_uncached(out_uncached), .out_fault(out_fault)
);

// File: tb/sim_ift_translator.sv
module sim_ift_translator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_va = '0;
  logic        in_pc_lsb = 1'b0;
  logic        in_phys = 1'b0;
  logic [1:0]  in_mode = '0;
  logic [7:0]  in_asn = '0;
  logic        lk_req;
  logic [34:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        lk_hit;
  logic [31:0] lk_ppn;
  logic [3:0]  lk_xre;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [43:0] out_pa;
  logic        out_uncached;
  logic [1:0]  out_fault;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ift_translator u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_va(in_va), .in_pc_lsb(in_pc_lsb), .in_phys(in_phys),
    .in_mode(in_mode), .in_asn(in_asn), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_xre(lk_xre),
    .out_valid(out_valid), .out_ready(out_ready), .out_pa(out_pa),
    .out_uncached(out_uncached), .out_fault(out_fault)
  );

  // bench page table model
  logic [34:0] m_vpn [8];
  logic [7:0]  m_asn [8];
  logic        m_glb [8];
  logic [31:0] m_ppn [8];
  logic [3:0]  m_xre [8];

  function automatic int find(input logic [34:0] vpn, input logic [7:0] asn);
    for (int i = 0; i < 8; i++)
      if (m_vpn[i] == vpn && (m_glb[i] || m_asn[i] == asn)) return i;
    return -1;
  endfunction

  always_comb begin
    int k;
    k = find(lk_vpn, lk_asn);
    lk_hit = (k >= 0);
    lk_ppn = (k >= 0) ? m_ppn[k] : 32'h0;
    lk_xre = (k >= 0) ? m_xre[k] : 4'h0;
  end

  // expected result from the requirements
  function automatic void model(input logic [63:0] va, input logic pcb, input logic ph,
                                input logic [1:0] md, input logic [7:0] asn,
                                output logic [1:0] f, output logic [43:0] pa,
                                output logic uc, output logic look);
    logic [63:0] full;
    int k;
    f = 2'd0; uc = 1'b0; pa = '0; look = 1'b0; full = '0;
    if (pcb) begin
      pa = va[43:0] & 44'hFFF_FFFF_FFFC;
      return;
    end
    if (ph) full = va;
    else if (!(va[63:47] == 17'h0 || va[63:47] == 17'h1FFFF)) f = 2'd1;
    else if (va[47:41] == 7'h7e) begin
      if (md != 2'd0) f = 2'd1;
      else begin
        full = va & 64'h0000_0FFF_FFFF_FFFF;
        if (full[40]) full = full | 64'h0000_0F00_0000_0000;
        else full = full & 64'h0000_00FF_FFFF_FFFF;
      end
    end else begin
      look = 1'b1;
      k = find(va[47:13], asn);
      if (k < 0) f = 2'd2;
      else begin
        full = ({32'h0, m_ppn[k]} << 13) + {51'h0, va[12:2], 2'b00};
        if (!m_xre[k][md]) f = 2'd1;
      end
    end
    if (f == 2'd0 && full[63:44] != 20'h0) f = 2'd3;
    if (f == 2'd0) begin
      pa = full[43:0];
      if (pa[43]) begin
        uc = 1'b1;
        pa[42:35] = 8'h0;
      end
    end
  endfunction

  function automatic string tag_of(input logic pcb, input logic ph, input logic [63:0] va,
                                   input logic [1:0] md, input logic [1:0] f, input logic uc);
    if (pcb) return "R1";
    if (f == 2'd3) return "R9";
    if (uc) return "R10";
    if (ph) return "R2";
    if (!(va[63:47] == 17'h0 || va[63:47] == 17'h1FFFF)) return "R3";
    if (va[47:41] == 7'h7e) return (md != 2'd0) ? "R4" : "R5";
    if (f == 2'd2) return "R6";
    if (f == 2'd1) return "R8";
    return "R7";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [63:0] va, input logic pcb, input logic ph,
                      input logic [1:0] md, input logic [7:0] asn);
    logic [1:0] f; logic [43:0] pa; logic uc, look;
    string t;
    model(va, pcb, ph, md, asn, f, pa, uc, look);
    t = tag_of(pcb, ph, va, md, f, uc);
    @(negedge clk);
    in_va = va; in_pc_lsb = pcb; in_phys = ph; in_mode = md; in_asn = asn;
    in_valid = 1'b1;
    #1;
    check("R13 lk_req", {63'h0, lk_req}, {63'h0, look});
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 out_valid", {63'h0, out_valid}, 64'h1);
    check({t, " fault"}, {62'h0, out_fault}, {62'h0, f});
    check({t, " pa"}, {20'h0, out_pa}, {20'h0, pa});
    check({t, " uncached"}, {63'h0, out_uncached}, {63'h0, uc});
    if (f != 2'd0) check("R14 zero on fault", {19'h0, out_pa, out_uncached}, 64'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] va;
    int sel;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin
      m_vpn[i] = {1'b0, $urandom(), 2'b00} ^ 35'(i);
      m_asn[i] = 8'(i + 3);
      m_glb[i] = (i == 5);
      m_ppn[i] = $urandom();
      m_xre[i] = 4'($urandom());
    end
    m_ppn[0] = 32'h0000_1234; m_xre[0] = 4'b0001;  // small ppn, kernel only
    m_ppn[1] = 32'h4000_0001; m_xre[1] = 4'b1111;  // lands on bit 43
    m_ppn[2] = 32'h8000_0000; m_xre[2] = 4'b1111;  // lands on bit 44

    repeat (3) @(negedge clk);
    check("R12 reset out_valid", {63'h0, out_valid}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 after reset", {63'h0, out_valid}, 64'h0);

    // directed corners
    xact(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b0, 2'd3, 8'h0);      // R1 marker, bit 43 kept, no uc
    xact(64'h0010_0000_0000_0000, 1'b0, 1'b1, 2'd0, 8'h0);      // R2 -> R9
    xact(64'h0000_0800_0000_1000, 1'b0, 1'b1, 2'd0, 8'h0);      // R2 -> R10
    xact(64'h0000_0012_3456_7890, 1'b0, 1'b1, 2'd1, 8'h0);      // R2 plain
    xact(64'h0001_0000_0000_0000, 1'b0, 1'b0, 2'd0, 8'h0);      // R3
    xact(64'hFFFF_FD01_2345_6789, 1'b0, 1'b0, 2'd2, 8'h0);      // R4
    xact(64'hFFFF_FD01_2345_6789, 1'b0, 1'b0, 2'd0, 8'h0);      // R5 bit40 set
    xact(64'hFFFF_FC01_2345_6789, 1'b0, 1'b0, 2'd0, 8'h0);      // R5 bit40 clear
    xact({16'h0, m_vpn[0], 13'h1FFF}, 1'b0, 1'b0, 2'd0, 8'd3);  // R7
    xact({16'h0, m_vpn[0], 13'h0005}, 1'b0, 1'b0, 2'd1, 8'd3);  // R8
    xact({16'h0, m_vpn[0], 13'h0005}, 1'b0, 1'b0, 2'd0, 8'd99); // R6 asn mismatch
    xact({16'h0, m_vpn[5], 13'h0010}, 1'b0, 1'b0, 2'd0, 8'd99); // global entry
    xact({16'h0, m_vpn[1], 13'h0044}, 1'b0, 1'b0, 2'd2, 8'd4);  // R10 via lookup
    xact({16'h0, m_vpn[2], 13'h0044}, 1'b0, 1'b0, 2'd2, 8'd5);  // R9 via lookup

    // R11 stall: A is held while B waits at the input
    @(negedge clk);
    out_ready = 1'b0;
    in_va = 64'h0000_0000_0000_ABC0; in_phys = 1'b1; in_pc_lsb = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_va = 64'h0000_0000_0000_1230;
    check("R11 in_ready low when full", {63'h0, in_ready}, 64'h0);
    check("R11 held pa", {20'h0, out_pa}, 64'hABC0);
    @(posedge clk);
    @(negedge clk);
    check("R11 still held pa", {20'h0, out_pa}, 64'hABC0);
    check("R11 still valid", {63'h0, out_valid}, 64'h1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_phys = 1'b0;
    check("R11 next result", {20'h0, out_pa}, 64'h1230);
    check("R11 next valid", {63'h0, out_valid}, 64'h1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      sel = $urandom_range(0, 5);
      case (sel)
        0: xact({$urandom(), $urandom()}, 1'b1, 1'($urandom()), 2'($urandom()), 8'($urandom()));
        1: begin
          va = {$urandom(), $urandom()};
          if ($urandom_range(0, 1) == 0) va[63:44] = '0;
          xact(va, 1'b0, 1'b1, 2'($urandom()), 8'($urandom()));
        end
        2: xact({16'h1234, $urandom(), 16'($urandom())}, 1'b0, 1'b0, 2'($urandom()), 8'($urandom()));
        3: xact({16'hFFFF, 7'h7e, 9'($urandom()), $urandom()}, 1'b0, 1'b0,
                2'($urandom_range(0, 1) == 0 ? 0 : $urandom()), 8'($urandom()));
        4: begin
          int k;
          k = $urandom_range(0, 7);
          xact({16'h0, m_vpn[k], 13'($urandom())}, 1'b0, 1'b0, 2'($urandom()),
               ($urandom_range(0, 3) == 0) ? 8'($urandom()) : m_asn[k]);
        end
        default: xact({16'h0, 1'b0, 34'({$urandom(), 2'b00}), 13'($urandom())}, 1'b0, 1'b0,
                      2'($urandom()), 8'($urandom()));
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule